// File: doc/BRIEF.md
# Serial Character Receiver with Idle-Line Detection

This block is the receive half of an asynchronous serial port. An external rate generator supplies `rx_tick`, a one-cycle enable that pulses sixteen times per bit period. The receiver synchronises the serial input and watches for a falling edge. It then takes three samples near the centre of every bit and keeps the majority value. LSB-first data bits are gathered in a shift register. When the stop bit has been judged, the character moves into a holding register and the full flag is raised.

Error conditions are flagged alongside the byte. These are disagreement among the three samples of any bit (noise), a low stop bit (framing) and a character that arrives while the previous one is still unread (overrun). A separate counter measures how long the line has stayed high. After ten bit times of high line it reports an idle line, but only once for each run of characters. Software clears the flags by reading status (`stat_rd`) and then the data (`data_rd`).

The control path is a five-state machine. `RX_OFF` is held while `rx_en` is low and moves to `RX_HUNT` when it is set. `RX_HUNT` goes to `RX_START` on a tick that sees the line low. `RX_START` falls back to `RX_HUNT` if the start-bit vote is high (false start), or proceeds to `RX_DATA` at the end of the bit. `RX_DATA` moves to `RX_STOP` after the last data bit. `RX_STOP` returns to `RX_HUNT` right after the stop-bit vote, so a following start edge is caught without losing half a bit. Clearing `rx_en` forces `RX_OFF` from any state.

Top module: `uart_rx_idle`

## Requirements
- R1: A frame is one low start bit, 8 data bits LSB first, and one stop bit, each 16 ticks long. Once the stop bit is judged, the byte appears on `rx_data` and `rx_full` goes to 1. After reset every flag and `irq` is 0.
- R2: Each bit is sampled on its 8th, 9th and 10th tick, and the majority value is kept. If the three samples of any bit in the frame disagree, `err_noise` is 1 with that byte, and the byte itself is still correct.
- R3: A stop bit whose majority is low sets `err_frame` to 1. The byte is still loaded.
- R4: A character that completes while `rx_full` is 1 leaves `rx_data` unchanged and sets `err_overrun`. `err_overrun` is never 1 while `rx_full` is 0.
- R5: If the start bit's majority vote is high, the receiver treats it as a false start and returns to hunting. No character is reported.
- R6: `line_idle` becomes 1 after 160 consecutive ticks of high line, counted from the last low sample. It is armed only by a character with a high stop bit, whether or not it overran. It fires once per arming: it stays 0 before the first such character and after a character with a framing error.
- R7: Asserting `data_rd` after an earlier `stat_rd` clears `rx_full`, `err_overrun`, `err_noise`, `err_frame` and `line_idle`. A `data_rd` without a prior `stat_rd` clears nothing.
- R8: `irq` is 1 when `full_ie` is 1 and (`rx_full` or `err_overrun`) is 1, or when `idle_ie` is 1 and `line_idle` is 1. Otherwise it is 0.
- R9: While `rx_en` is 0 the state machine is held in `RX_OFF`, the line is ignored, and `rx_data` reads 0. The held byte reappears when `rx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_tick | input | 1 | Sixteen-per-bit sampling enable |
| rx_line | input | 1 | Serial input, idle high |
| rx_en | input | 1 | Receiver enable |
| stat_rd | input | 1 | Status read strobe (arms the clear) |
| data_rd | input | 1 | Data read strobe (clears flags when armed) |
| full_ie | input | 1 | Interrupt enable for full/overrun |
| idle_ie | input | 1 | Interrupt enable for idle line |
| rx_data | output | 8 | Received byte, 0 while disabled |
| rx_full | output | 1 | Data register holds an unread byte |
| err_overrun | output | 1 | Character lost because the register was full |
| err_noise | output | 1 | Sample disagreement in the held character |
| err_frame | output | 1 | Stop bit read low in the held character |
| line_idle | output | 1 | Idle line seen after a valid character |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a single deviant sample: one sample of a bit must differ while the other two still carry the majority. The bench changes the line only on the falling clock edge after a tick. It counts the two synchroniser stages against a four-clock tick spacing, so each driven value lands on exactly one receiver tick. It can then invert just the 9th tick of a chosen bit. The idle window is checked the same way: by tick count, a little before and after the 160-tick boundary. This is done once after a valid character and again after a character with a framing error.

// File: rtl/urx_pkg.sv
package urx_pkg;

    typedef enum logic [2:0] {
        RX_OFF,
        RX_HUNT,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // Two-of-three vote used on every bit.
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/urx_frame_fsm.sv
module urx_frame_fsm
    import urx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16,
    parameter int MID       = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 tick,
    input  logic                 line,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 noise,
    output logic                 frame_err,
    output logic                 busy
);
    localparam int CNT_W = $clog2(OVS + 1);
    localparam int BIT_W = $clog2(DATA_BITS + 1);
    localparam logic [CNT_W-1:0] S_LO  = CNT_W'(MID - 1);
    localparam logic [CNT_W-1:0] S_MID = CNT_W'(MID);
    localparam logic [CNT_W-1:0] S_HI  = CNT_W'(MID + 1);
    localparam logic [CNT_W-1:0] S_END = CNT_W'(OVS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

    rx_state_e            state, nxt;
    logic [CNT_W-1:0]     cnt;
    logic [BIT_W-1:0]     bitn;
    logic [DATA_BITS-1:0] shreg;
    logic [1:0]           smp;
    logic                 noise_acc;
    logic                 vote;
    logic                 disagree;

    assign vote     = vote3(smp[1], smp[0], line);
    assign disagree = !((smp[1] == smp[0]) && (smp[0] == line));

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            RX_OFF:   if (en) nxt = RX_HUNT;
            RX_HUNT:  if (tick && !line) nxt = RX_START;
            RX_START: begin
                if (tick && cnt == S_HI && vote)  nxt = RX_HUNT;
                else if (tick && cnt == S_END)    nxt = RX_DATA;
            end
            RX_DATA:  if (tick && cnt == S_END && bitn == LAST_BIT) nxt = RX_STOP;
            RX_STOP:  if (tick && cnt == S_HI) nxt = RX_HUNT;
            default:  nxt = RX_OFF;
        endcase
        if (!en) nxt = RX_OFF;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_OFF;
        else        state <= nxt;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            bitn      <= '0;
            shreg     <= '0;
            smp       <= 2'b11;
            noise_acc <= 1'b0;
            done      <= 1'b0;
            noise     <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                cnt       <= '0;
                bitn      <= '0;
                noise_acc <= 1'b0;
            end else if (tick) begin
                unique case (state)
                    RX_HUNT: begin
                        if (!line) begin
                            cnt       <= CNT_W'(1);
                            bitn      <= '0;
                            noise_acc <= 1'b0;
                        end
                    end
                    RX_START, RX_DATA, RX_STOP: begin
                        cnt <= (cnt == S_END) ? CNT_W'(1) : cnt + 1'b1;
                        if (cnt == S_LO)  smp[1] <= line;
                        if (cnt == S_MID) smp[0] <= line;
                        if (cnt == S_HI) begin
                            if (disagree) noise_acc <= 1'b1;
                            if (state == RX_DATA)
                                shreg <= {vote, shreg[DATA_BITS-1:1]};
                            if (state == RX_STOP) begin
                                done      <= 1'b1;
                                frame_err <= !vote;
                                noise     <= noise_acc | disagree;
                            end
                        end
                        if (state == RX_DATA && cnt == S_END)
                            bitn <= bitn + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign data = shreg;
    assign busy = (state == RX_START) || (state == RX_DATA) || (state == RX_STOP);
endmodule

// File: rtl/urx_idle_det.sv
module urx_idle_det #(
    parameter int IDLE_TICKS = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic line,
    input  logic char_ok,
    output logic idle_hit,
    output logic armed
);
    localparam int W = $clog2(IDLE_TICKS + 1);
    localparam logic [W-1:0] LIMIT = W'(IDLE_TICKS);
    localparam logic [W-1:0] FIRE  = W'(IDLE_TICKS - 1);

    logic [W-1:0] cnt;

    assign idle_hit = en && tick && line && armed && (cnt == FIRE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (!en) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else begin
            if (tick) begin
                if (!line)              cnt <= '0;
                else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
            end
            if (idle_hit)      armed <= 1'b0;
            else if (char_ok)  armed <= 1'b1;
        end
    end
endmodule

// File: rtl/urx_status.sv
module urx_status #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] ch_data,
    input  logic                 ch_noise,
    input  logic                 ch_frame,
    input  logic                 idle_hit,
    input  logic                 stat_rd,
    input  logic                 data_rd,
    output logic [DATA_BITS-1:0] dreg,
    output logic                 full,
    output logic                 ovr,
    output logic                 nse,
    output logic                 frm,
    output logic                 idle
);
    logic rd_armed;
    logic clr;

    assign clr = data_rd && rd_armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_armed <= 1'b0;
            dreg     <= '0;
            full     <= 1'b0;
            ovr      <= 1'b0;
            nse      <= 1'b0;
            frm      <= 1'b0;
            idle     <= 1'b0;
        end else begin
            if (data_rd)      rd_armed <= 1'b0;
            else if (stat_rd) rd_armed <= 1'b1;

            if (clr) begin
                full <= 1'b0;
                ovr  <= 1'b0;
                nse  <= 1'b0;
                frm  <= 1'b0;
                idle <= 1'b0;
            end
            if (done) begin
                if (full && !clr) begin
                    ovr <= 1'b1;
                end else begin
                    dreg <= ch_data;
                    full <= 1'b1;
                    nse  <= ch_noise;
                    frm  <= ch_frame;
                end
            end
            if (idle_hit) idle <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int IDLE_BITS   = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_tick,
    input  logic                 rx_line,
    input  logic                 rx_en,
    input  logic                 stat_rd,
    input  logic                 data_rd,
    input  logic                 full_ie,
    input  logic                 idle_ie,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_full,
    output logic                 err_overrun,
    output logic                 err_noise,
    output logic                 err_frame,
    output logic                 line_idle,
    output logic                 irq
);
    localparam int MID        = OVS / 2 + 1;
    localparam int IDLE_TICKS = IDLE_BITS * OVS;

    logic                 line_s;
    logic                 chr_done;
    logic [DATA_BITS-1:0] chr_data;
    logic                 chr_noise;
    logic                 chr_frame;
    logic                 rx_busy;
    logic                 idle_hit;
    logic                 idle_armed;
    logic [DATA_BITS-1:0] dreg;

    urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s)
    );

    urx_frame_fsm #(.DATA_BITS(DATA_BITS), .OVS(OVS), .MID(MID)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rx_en),
        .tick     (rx_tick),
        .line     (line_s),
        .done     (chr_done),
        .data     (chr_data),
        .noise    (chr_noise),
        .frame_err(chr_frame),
        .busy     (rx_busy)
    );

    urx_idle_det #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_en),
        .tick    (rx_tick),
        .line    (line_s),
        .char_ok (chr_done && !chr_frame),
        .idle_hit(idle_hit),
        .armed   (idle_armed)
    );

    urx_status #(.DATA_BITS(DATA_BITS)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (chr_done),
        .ch_data (chr_data),
        .ch_noise(chr_noise),
        .ch_frame(chr_frame),
        .idle_hit(idle_hit),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .dreg    (dreg),
        .full    (rx_full),
        .ovr     (err_overrun),
        .nse     (err_noise),
        .frm     (err_frame),
        .idle    (line_idle)
    );

    assign rx_data = rx_en ? dreg : '0;
    assign irq     = (full_ie && (rx_full || err_overrun)) || (idle_ie && line_idle);
endmodule

// File: rtl/urx_chk.sv
module urx_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_en,
    input logic                 data_rd,
    input logic                 full_ie,
    input logic                 idle_ie,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_full,
    input logic                 err_overrun,
    input logic                 line_idle,
    input logic                 irq,
    input logic                 chr_done,
    input logic                 rx_busy,
    input logic                 idle_armed
);
    p_full_from_char_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(chr_done));

    p_overrun_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && chr_done && !data_rd) |=> err_overrun);

    p_overrun_keeps_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && chr_done && !data_rd && rx_en) |=> (!rx_en || $stable(rx_data)));

    p_overrun_implies_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |-> rx_full);

    p_clear_needs_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(data_rd));

    p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (full_ie || idle_ie));

    p_idle_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_idle) |-> $past(idle_armed));

    p_off_when_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_busy);
endmodule

bind uart_rx_idle urx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .data_rd    (data_rd),
    .full_ie    (full_ie),
    .idle_ie    (idle_ie),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .err_overrun(err_overrun),
    .line_idle  (line_idle),
    .irq        (irq),
    .chr_done   (chr_done),
    .rx_busy    (rx_busy),
    .idle_armed (idle_armed)
);

// File: tb/tb_uart_rx_idle.sv
module tb_uart_rx_idle;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       rx_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic       data_rd = 1'b0;
    logic       full_ie = 1'b0;
    logic       idle_ie = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, err_overrun, err_noise, err_frame, line_idle, irq;

    int checks = 0;
    int fails  = 0;
    int div    = 0;
    bit auto_rd = 1'b0;

    typedef struct {
        logic [7:0] d;
        logic       nf;
        logic       fe;
    } exp_t;
    exp_t exp_q[$];
    exp_t e;

    uart_rx_idle dut (
        .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_line(rx_line),
        .rx_en(rx_en), .stat_rd(stat_rd), .data_rd(data_rd),
        .full_ie(full_ie), .idle_ie(idle_ie), .rx_data(rx_data),
        .rx_full(rx_full), .err_overrun(err_overrun), .err_noise(err_noise),
        .err_frame(err_frame), .line_idle(line_idle), .irq(irq)
    );

    initial forever #2 clk = ~clk;

    // Tick every fourth clock, changed on the falling edge.
    initial forever begin
        @(negedge clk);
        div     = (div + 1) % 4;
        rx_tick = (div == 0);
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!rx_tick);
            @(negedge clk);
        end
    endtask

    // gbit: -1 none, 0 start, 1..8 data, 9 stop; inverts tick 9 of that bit only
    task automatic send_frame(input logic [7:0] d, input int gbit, input logic stop_v, input bit push);
        logic [9:0] bits;
        bits = {stop_v, d, 1'b0};
        if (push) exp_q.push_back('{d, (gbit >= 0), !stop_v});
        wait_ticks(1);
        for (int b = 0; b < 10; b++) begin
            for (int k = 1; k <= 16; k++) begin
                rx_line = (b == gbit && k == 9) ? ~bits[b] : bits[b];
                wait_ticks(1);
            end
        end
        rx_line = 1'b1;
    endtask

    task automatic read_seq();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        @(negedge clk);
    endtask

    // Scoreboard monitor
    initial forever begin
        @(negedge clk);
        if (auto_rd && rx_full) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected character", rx_data, 0);
            end else begin
                e = exp_q.pop_front();
                chk(rx_data == e.d, "R1 data byte", rx_data, e.d);
                chk(err_noise == e.nf, "R2 noise flag", err_noise, e.nf);
                chk(err_frame == e.fe, "R3 framing flag", err_frame, e.fe);
            end
            read_seq();
            chk(!rx_full && !err_noise && !err_frame, "R7 flags cleared by read pair",
                {rx_full, err_noise, err_frame}, 0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rx_full && !err_overrun && !err_noise && !err_frame, "R1 reset flags",
            {rx_full, err_overrun, err_noise, err_frame}, 0);
        chk(!irq, "R8 reset irq", irq, 0);
        chk(!line_idle, "R6 reset idle", line_idle, 0);
        chk(rx_data == 8'h00, "R9 data reads zero while disabled", rx_data, 0);

        rx_en = 1'b1;
        wait_ticks(200);
        chk(!line_idle, "R6 no idle before any character", line_idle, 0);

        // Clean characters through the scoreboard
        auto_rd = 1'b1;
        full_ie = 1'b1;
        send_frame(8'hA5, -1, 1'b1, 1'b1);
        send_frame(8'h3C, -1, 1'b1, 1'b1);
        send_frame(8'h00, -1, 1'b1, 1'b1);
        send_frame(8'hFF, -1, 1'b1, 1'b1);
        // Single deviant samples
        send_frame(8'h5A, 4, 1'b1, 1'b1);
        send_frame(8'hC3, 0, 1'b1, 1'b1);
        // Low stop bit
        send_frame(8'h81, -1, 1'b0, 1'b1);
        wait_ticks(20);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);

        // R5: false start (low for 5 ticks only)
        wait_ticks(1);
        rx_line = 1'b0;
        wait_ticks(5);
        rx_line = 1'b1;
        wait_ticks(40);
        chk(!rx_full, "R5 false start yields no character", rx_full, 0);
        send_frame(8'h11, -1, 1'b1, 1'b1);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        auto_rd = 1'b0;
        repeat (4) @(negedge clk);

        // R4: overrun
        send_frame(8'h12, -1, 1'b1, 1'b0);
        send_frame(8'h34, -1, 1'b1, 1'b0);
        wait_ticks(2);
        chk(rx_full, "R4 full after overrun", rx_full, 1);
        chk(err_overrun, "R4 overrun flag", err_overrun, 1);
        chk(rx_data == 8'h12, "R4 data register kept", rx_data, 8'h12);
        chk(irq, "R8 irq from full with enable", irq, 1);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        @(negedge clk);
        chk(rx_full && err_overrun, "R7 data read alone clears nothing", {rx_full, err_overrun}, 2'b11);
        read_seq();
        chk(!rx_full && !err_overrun, "R7 read pair clears full and overrun", {rx_full, err_overrun}, 0);

        // R6: overrun character still arms idle
        wait_ticks(200);
        chk(line_idle, "R6 idle after overrun character", line_idle, 1);
        read_seq();
        chk(!line_idle, "R7 read pair clears idle", line_idle, 0);

        // R6/R8: idle window edges
        full_ie = 1'b0;
        idle_ie = 1'b1;
        send_frame(8'h00, -1, 1'b1, 1'b0);
        wait_ticks(130);
        chk(!line_idle, "R6 idle not yet at 146 high ticks", line_idle, 0);
        chk(!irq, "R8 full masked when its enable is 0", irq, 0);
        wait_ticks(20);
        chk(line_idle, "R6 idle at 166 high ticks", line_idle, 1);
        chk(irq, "R8 irq from idle with enable", irq, 1);
        read_seq();
        wait_ticks(300);
        chk(!line_idle, "R6 idle fires once per arming", line_idle, 0);

        // R3/R6: framing error loads byte, does not arm idle
        send_frame(8'h81, -1, 1'b0, 1'b0);
        wait_ticks(2);
        chk(err_frame, "R3 framing flag set", err_frame, 1);
        chk(rx_data == 8'h81, "R3 byte loaded with framing error", rx_data, 8'h81);
        read_seq();
        wait_ticks(300);
        chk(!line_idle, "R6 framing error does not arm idle", line_idle, 0);

        // R9: disabled receiver
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(rx_data == 8'h00, "R9 data hidden while disabled", rx_data, 0);
        send_frame(8'h77, -1, 1'b1, 1'b0);
        wait_ticks(2);
        chk(!rx_full, "R9 line ignored while disabled", rx_full, 0);
        rx_en = 1'b1;
        wait_ticks(2);
        chk(rx_data == 8'h81, "R9 held byte visible again", rx_data, 8'h81);
        send_frame(8'h66, -1, 1'b1, 1'b0);
        wait_ticks(2);
        chk(rx_full && rx_data == 8'h66, "R9 reception resumes", rx_data, 8'h66);

        finish_run();
    end
endmodule